// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Demultiplexer Mode

This block keeps eight output bits, each of which can be reached through a three-bit address. A single data input, an active-low enable and an active-low clear steer how the bits change. The pair of active-low controls picks one of four behaviours:

- write the data bit into the addressed position;
- keep every bit as it is;
- force all bits to zero;
- act as a one-of-eight demultiplexer, where the addressed bit follows the data input and every other bit is driven low.

All state lives in flip-flops clocked on the rising edge of a system clock. The controls, address and data are sampled at that edge in place of level-sensitive transparency. A synchronous active-high reset zeroes the whole word.

A typical use is as a bank of individually settable control flags. It can also serve as a decoder that raises one line out of eight under control of the data input.

Top module: `addr_latch8`

## Requirements
- R1: While `rst` is high at a rising edge, `q` becomes all zeros at that edge, whatever the other inputs are.
- R2: With `en_n`=0 and `clr_n`=1 at an edge, bit `q[addr]` takes the value of `d`, and every other bit of `q` keeps its value.
- R3: With `en_n`=1 and `clr_n`=1 at an edge, all of `q` keeps its value, for any `addr` and `d`.
- R4: With `en_n`=1 and `clr_n`=0 at an edge, all of `q` becomes zero, for any `addr` and `d`.
- R5: With `en_n`=0 and `clr_n`=0 at an edge, `q[addr]` takes `d` and every other bit of `q` becomes zero, so `q` has at most one bit set.
- R6: Address value i (binary, bit 0 least significant) selects output bit `q[i]`, for every i from 0 to 7.
- R7: In write mode, a bit written at one edge keeps its value after later edges write other addresses.
- R8: Reset takes priority over all four modes. A write of 1 sampled in the same cycle as reset leaves `q` at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset of all output bits |
| en_n | input | 1 | Active-low enable; with `clr_n` selects the mode |
| clr_n | input | 1 | Active-low clear; with `en_n` selects the mode |
| addr | input | 3 | Index of the bit affected by write and demultiplexer modes |
| d | input | 1 | Data value for the addressed bit |
| q | output | 8 | Registered output bits, `q[i]` addressed by value i |

## Verification
The assertions assume two things about the inputs. First, the control pair, address and data are stable and known at every rising edge. Second, `addr` never names a bit beyond the output width.

The stimulus keeps to these assumptions. It changes every input only on the falling edge, and it walks `addr` only through the values 0 to 7.

It also places mode changes on consecutive edges. This way each per-mode property is checked against a state left behind by a different mode.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

    // Encoding is {en_n, clr_n} as sampled at the clock edge
    typedef enum logic [1:0] {
        MODE_DEMUX = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_WIPE  = 2'b10,
        MODE_HOLD  = 2'b11
    } latch_mode_e;

endpackage

// File: rtl/al_mode_dec.sv
module al_mode_dec
    import addr_latch_pkg::*;
(
    input  logic        en_n,
    input  logic        clr_n,
    output latch_mode_e mode
);

    always_comb begin
        unique case ({en_n, clr_n})
            2'b00:   mode = MODE_DEMUX;
            2'b01:   mode = MODE_WRITE;
            2'b10:   mode = MODE_WIPE;
            default: mode = MODE_HOLD;
        endcase
    end

endmodule

// File: rtl/al_addr_dec.sv
module al_addr_dec #(
    parameter int NBITS = 8,
    parameter int AW    = 3
) (
    input  logic [AW-1:0]    addr,
    output logic [NBITS-1:0] sel
);

    always_comb begin
        sel = '0;
        for (int i = 0; i < NBITS; i++) begin
            if (addr == AW'(i)) sel[i] = 1'b1;
        end
    end

endmodule

// File: rtl/al_bit_next.sv
module al_bit_next
    import addr_latch_pkg::*;
(
    input  latch_mode_e mode,
    input  logic        sel,
    input  logic        d,
    input  logic        cur,
    output logic        nxt
);

    always_comb begin
        unique case (mode)
            MODE_WRITE: nxt = sel ? d : cur;
            MODE_HOLD:  nxt = cur;
            MODE_WIPE:  nxt = 1'b0;
            MODE_DEMUX: nxt = sel & d;
            default:    nxt = cur;
        endcase
    end

endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
    import addr_latch_pkg::*;
#(
    parameter  int NBITS = 8,
    localparam int AW    = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_n,
    input  logic             clr_n,
    input  logic [AW-1:0]    addr,
    input  logic             d,
    output logic [NBITS-1:0] q
);

    typedef struct packed {
        logic [NBITS-1:0] bits;
    } latch_state_t;

    latch_state_t state_d, state_q;
    latch_mode_e  mode;
    logic [NBITS-1:0] sel;
    logic [NBITS-1:0] bits_nxt;

    al_mode_dec u_mode (
        .en_n  (en_n),
        .clr_n (clr_n),
        .mode  (mode)
    );

    al_addr_dec #(.NBITS(NBITS), .AW(AW)) u_addr (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < NBITS; i++) begin : g_slice
        al_bit_next u_bit (
            .mode (mode),
            .sel  (sel[i]),
            .d    (d),
            .cur  (state_q.bits[i]),
            .nxt  (bits_nxt[i])
        );
    end

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.bits = '0;
        end else begin
            state_d.bits = bits_nxt;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign q = state_q.bits;

    // R2
    write_target_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_n && clr_n) |=> (q[$past(addr)] == $past(d)));

    // R2
    write_single_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_n && clr_n) |=> ($countones(q ^ $past(q)) <= 1));

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (en_n && clr_n) |=> $stable(q));

    // R4
    wipe_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (en_n && !clr_n) |=> (q == '0));

    // R5
    demux_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_n && !clr_n) |=> ($onehot0(q) && (q[$past(addr)] == $past(d))));

endmodule

// File: tb/addr_latch8_test.sv
module addr_latch8_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       en_n;
    logic       clr_n;
    logic [2:0] addr;
    logic       d;
    logic [7:0] q;

    logic [7:0] model;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    addr_latch8 uut (
        .clk   (clk),
        .rst   (rst),
        .en_n  (en_n),
        .clr_n (clr_n),
        .addr  (addr),
        .d     (d),
        .q     (q)
    );

    task automatic check(input string tag, input logic [7:0] expv);
        checks++;
        if (q !== expv) begin
            errors++;
            $display("FAIL %s: q=%b expected %b", tag, q, expv);
        end
    endtask

    // Drive on a falling edge, let one rising edge pass, compare on the next falling edge
    task automatic step(input logic e, input logic c, input logic [2:0] a,
                        input logic dv, input string tag);
        en_n = e; clr_n = c; addr = a; d = dv;
        case ({e, c})
            2'b01: model[a] = dv;
            2'b11: ;
            2'b10: model = '0;
            default: begin model = '0; model[a] = dv; end
        endcase
        @(posedge clk);
        @(negedge clk);
        check(tag, model);
    endtask

    task automatic t_reset();
        rst = 1'b1; en_n = 1'b1; clr_n = 1'b1; addr = '0; d = 1'b0;
        @(negedge clk); @(negedge clk);
        model = '0;
        check("R1 reset", 8'h00);
        rst = 1'b0;
    endtask

    task automatic t_write_each();
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 3'(i), 1'b1, "R6 write addr");
        for (int i = 7; i >= 0; i -= 2) step(1'b0, 1'b1, 3'(i), 1'b0, "R2 write zero");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 3'(i), ~model[i], "R3 hold");
    endtask

    task automatic t_wipe();
        step(1'b0, 1'b1, 3'd5, 1'b1, "R2 setup");
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b1, 3'(i), 1'b1, "R2 refill");
            step(1'b1, 1'b0, 3'(i), 1'b1, "R4 wipe");
        end
    endtask

    task automatic t_demux();
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b1, 3'((i + 3) % 8), 1'b1, "R2 pre");
            step(1'b0, 1'b0, 3'(i), 1'b1, "R5 demux one");
            step(1'b0, 1'b0, 3'(i), 1'b0, "R5 demux zero");
        end
    endtask

    task automatic t_addr_walk();
        step(1'b0, 1'b1, 3'd2, 1'b1, "R7 first");
        step(1'b0, 1'b1, 3'd6, 1'b1, "R7 second");
        step(1'b0, 1'b1, 3'd0, 1'b0, "R7 other");
        step(1'b0, 1'b1, 3'd4, 1'b0, "R7 other");
        checks++;
        if (q[2] !== 1'b1 || q[6] !== 1'b1) begin
            errors++;
            $display("FAIL R7 retained: q=%b expected bits 2 and 6 set", q);
        end
    endtask

    task automatic t_back_to_back();
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b1, 3'(i), 1'b1, "R2 b2b write");
            step(1'b0, 1'b0, 3'(7 - i), 1'b1, "R5 b2b demux");
            step(1'b1, 1'b1, 3'(i), 1'b0, "R3 b2b hold");
            step(1'b0, 1'b1, 3'(i), 1'b1, "R2 b2b write");
            step(1'b1, 1'b0, 3'(i), 1'b1, "R4 b2b wipe");
        end
    endtask

    task automatic t_reset_priority();
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 3'(i), 1'b1, "R2 fill");
        rst = 1'b1; en_n = 1'b0; clr_n = 1'b1; addr = 3'd3; d = 1'b1;
        @(posedge clk); @(negedge clk);
        model = '0;
        check("R8 reset over write", 8'h00);
        en_n = 1'b0; clr_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8 reset over demux", 8'h00);
        rst = 1'b0;
        step(1'b1, 1'b1, 3'd3, 1'b1, "R1 after reset");
    endtask

    initial begin
        model = '0;
        t_reset();
        t_write_each();
        t_hold();
        t_wipe();
        t_demux();
        t_addr_walk();
        t_back_to_back();
        t_reset_priority();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule